// File: doc/BRIEF.md
# I2C Target Register Read Engine

This block is the read side of an I2C target that serves a small bank of 16-bit registers to a bus controller. Every access opens with a write phase that carries one command byte. That byte selects a register and picks one of two read modes. A repeated START then turns the bus around to read. The target shifts out whole register words, high byte first, for as long as the controller acknowledges each byte.

The first `N_EXT` registers mirror a parallel input port. The register right after them is an internal alert status register. It gathers event bits, which it holds until a single-register read clears them. All other pointer values read as zero. A timeout returns the interface to idle if SCL is held low for too long. SDA is open drain: the block only says when to pull the line low.

Top module: `i2c_reg_reader`

## Requirements
- R1: The target ACKs an address byte whose upper 7 bits equal `DEV_ADDR`. It never ACKs any other address, and after a mismatch it leaves SDA released until the next START.
- R2: The target ACKs the command byte. Bit 7 of that byte is the auto-increment flag and bits 3:0 are the register pointer.
- R3: In a read phase each word goes out as its bits 15:8 first, then bits 7:0, each byte MSB first. A low bit pulls SDA low and a high bit leaves SDA released. The target waits for the controller's acknowledge after every byte.
- R4: With auto-increment at 0, every word of one read phase comes from the same register.
- R5: With auto-increment at 1, the pointer advances by one, wrapping from 15 to 0, after each complete word that the controller ACKs.
- R6: Pointers 0 to `N_EXT`-1 read `reg_data_i[16*p +: 16]`. Pointer `N_EXT` reads the alert register. Every other pointer reads 16'h0000.
- R7: Each alert bit is set by a high `alert_set_i` bit and stays set. The bits that were sent are cleared only when the read phase ends with a NACK after a complete alert word and the pointer did not advance in that phase. Neither a burst nor a NACK after only the high byte clears anything.
- R8: After a NACK the target releases SDA and drives nothing until the next START.
- R9: A START at any time restarts address reception. A STOP returns the block to idle with SDA released.
- R10: If SCL stays low for `TO_CYC` clock cycles while a transaction is in progress, the target releases SDA and goes idle. It does not release earlier.
- R11: During and after reset, SDA is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| reg_data_i | input | 16*N_EXT | Parallel contents of the externally held registers |
| alert_set_i | input | 16 | Per-bit alert event pulses |

## Verification
Both bus lines pass through a two-flop synchronizer and one edge register. The target therefore changes SDA two to three clock cycles after an SCL falling edge. The bench changes its own lines only while SCL is low and samples SDA a quarter bit period (8 cycles) after SCL rises, well after that latency. Alert-clear effects are checked through a second bus read, never by looking inside the design. Timeout is checked twice: once half-way through the `TO_CYC` window, when SDA must still be driven, and again 50 cycles after the window ends, when it must be released.

// File: rtl/i2c_rr_pkg.sv
package i2c_rr_pkg;
  localparam int WORD_W = 16;
  localparam int PTR_W  = 4;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_CMD, ST_CMD_ACK, ST_TX, ST_TX_ACK, ST_WAIT
  } rr_state_e;
endpackage

// File: rtl/i2c_rr_sync.sv
module i2c_rr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic rise_o,
  output logic fall_o,
  output logic start_o,
  output logic stop_o
);
  // bit 0 = scl, bit 1 = sda; extra stage keeps the previous value for edge detection
  logic [STAGES:0][1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '1;
    else         sh_q <= {sh_q[STAGES-1:0], {sda_i, scl_i}};
  end

  logic scl_p, sda_p;
  assign scl_o   = sh_q[STAGES-1][0];
  assign sda_o   = sh_q[STAGES-1][1];
  assign scl_p   = sh_q[STAGES][0];
  assign sda_p   = sh_q[STAGES][1];
  assign rise_o  = scl_o & ~scl_p;
  assign fall_o  = ~scl_o & scl_p;
  assign start_o = scl_o & scl_p & sda_p & ~sda_o;
  assign stop_o  = scl_o & scl_p & ~sda_p & sda_o;
endmodule

// File: rtl/i2c_rr_timeout.sv
module i2c_rr_timeout #(
  parameter int TO_CYC = 2000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  input  logic scl_i,
  output logic expire_o
);
  localparam int CW = $clog2(TO_CYC + 1);
  logic [CW-1:0] cnt_q;

  assign expire_o = active_i & ~scl_i & (cnt_q == CW'(TO_CYC - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (!active_i || scl_i)    cnt_q <= '0;
    else if (expire_o)              cnt_q <= '0;
    else                            cnt_q <= cnt_q + 1'b1;
  end

  AST_TO_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CW'(TO_CYC)); // R10
endmodule

// File: rtl/i2c_rr_regs.sv
module i2c_rr_regs
  import i2c_rr_pkg::*;
#(
  parameter int N_EXT = 3
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [N_EXT*WORD_W-1:0] reg_data_i,
  input  logic [WORD_W-1:0]       alert_set_i,
  input  logic                    clr_i,
  input  logic [WORD_W-1:0]       mask_i,
  input  logic [PTR_W-1:0]        idx_i,
  output logic [WORD_W-1:0]       word_o
);
  localparam logic [PTR_W-1:0] ALERT_IDX = PTR_W'(N_EXT);

  logic [WORD_W-1:0] ext_w [N_EXT];
  logic [WORD_W-1:0] alert_q;

  for (genvar g = 0; g < N_EXT; g++) begin : g_ext
    assign ext_w[g] = reg_data_i[g*WORD_W +: WORD_W];
  end

  always_comb begin
    word_o = '0;
    for (int i = 0; i < N_EXT; i++)
      if (idx_i == PTR_W'(i)) word_o = ext_w[i];
    if (idx_i == ALERT_IDX) word_o = alert_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    alert_q <= '0;
    else if (clr_i) alert_q <= (alert_q & ~mask_i) | alert_set_i;
    else            alert_q <= alert_q | alert_set_i;
  end

  AST_ALERT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> (alert_q & $past(alert_q)) == $past(alert_q)); // R7
  AST_ALERT_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (alert_q & $past(mask_i) & ~$past(alert_set_i)) == '0); // R7
endmodule

// File: rtl/i2c_reg_reader.sv
module i2c_reg_reader
  import i2c_rr_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h48,
  parameter int         N_EXT       = 3,
  parameter int         TO_CYC      = 2000,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    scl_i,
  input  logic                    sda_i,
  output logic                    sda_oe_o,
  input  logic [N_EXT*WORD_W-1:0] reg_data_i,
  input  logic [WORD_W-1:0]       alert_set_i
);
  localparam logic [PTR_W-1:0] ALERT_IDX = PTR_W'(N_EXT);

  logic scl_s, sda_s, rise, fall, start, stop, tmo;
  rr_state_e st_q;
  logic [BYTE_W-1:0] rx_q, tx_q;
  logic [WORD_W-1:0] word_q, rd_word;
  logic [2:0] cnt_q;
  logic got8_q, rw_q, autoinc_q, bsel_q, burst_q, ack_q, clr_q, oe_q;
  logic [PTR_W-1:0] ptr_q;

  i2c_rr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s), .rise_o(rise), .fall_o(fall),
    .start_o(start), .stop_o(stop)
  );

  i2c_rr_timeout #(.TO_CYC(TO_CYC)) u_tmo (
    .clk_i, .rst_ni, .active_i(st_q != ST_IDLE), .scl_i(scl_s), .expire_o(tmo)
  );

  i2c_rr_regs #(.N_EXT(N_EXT)) u_regs (
    .clk_i, .rst_ni, .reg_data_i, .alert_set_i,
    .clr_i(clr_q), .mask_i(word_q), .idx_i(ptr_q), .word_o(rd_word)
  );

  assign sda_oe_o = oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE;  rx_q <= '0;  tx_q <= '0;  word_q <= '0;  cnt_q <= '0;
      got8_q <= 1'b0;  rw_q <= 1'b0;  autoinc_q <= 1'b0;  bsel_q <= 1'b0;
      burst_q <= 1'b0;  ack_q <= 1'b0;  clr_q <= 1'b0;  oe_q <= 1'b0;  ptr_q <= '0;
    end else begin
      clr_q <= 1'b0;
      if (tmo) begin
        st_q <= ST_IDLE;  oe_q <= 1'b0;
      end else if (start) begin
        st_q <= ST_ADDR;  cnt_q <= '0;  got8_q <= 1'b0;  oe_q <= 1'b0;
      end else if (stop) begin
        st_q <= ST_IDLE;  oe_q <= 1'b0;
      end else begin
        unique case (st_q)
          ST_ADDR, ST_CMD: begin
            if (rise) begin
              rx_q  <= {rx_q[BYTE_W-2:0], sda_s};
              cnt_q <= cnt_q + 1'b1;
              if (cnt_q == 3'd7) got8_q <= 1'b1;
            end else if (fall && got8_q) begin
              got8_q <= 1'b0;
              cnt_q  <= '0;
              if (st_q == ST_ADDR) begin
                if (rx_q[7:1] == DEV_ADDR) begin
                  st_q <= ST_ADDR_ACK;  oe_q <= 1'b1;  rw_q <= rx_q[0];
                end else begin
                  st_q <= ST_WAIT;
                end
              end else begin
                autoinc_q <= rx_q[7];
                ptr_q     <= rx_q[PTR_W-1:0];
                oe_q      <= 1'b1;
                st_q      <= ST_CMD_ACK;
              end
            end
          end
          ST_ADDR_ACK: if (fall) begin
            if (rw_q) begin
              st_q <= ST_TX;  word_q <= rd_word;  tx_q <= rd_word[WORD_W-1 -: BYTE_W];
              oe_q <= ~rd_word[WORD_W-1];  bsel_q <= 1'b0;  burst_q <= 1'b0;  cnt_q <= '0;
            end else begin
              st_q <= ST_CMD;  oe_q <= 1'b0;
            end
          end
          ST_CMD_ACK: if (fall) begin
            oe_q <= 1'b0;  st_q <= ST_WAIT;
          end
          ST_TX: if (fall) begin
            if (cnt_q == 3'd7) begin
              oe_q <= 1'b0;  st_q <= ST_TX_ACK;
            end else begin
              tx_q  <= {tx_q[BYTE_W-2:0], 1'b0};
              oe_q  <= ~tx_q[BYTE_W-2];
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_TX_ACK: begin
            if (rise) begin
              ack_q <= ~sda_s;
              // pointer moves before the next fall so rd_word is settled when loaded
              if (!sda_s && bsel_q && autoinc_q) begin
                ptr_q <= ptr_q + 1'b1;  burst_q <= 1'b1;
              end
              if (sda_s && bsel_q && !burst_q && ptr_q == ALERT_IDX) clr_q <= 1'b1;
            end else if (fall) begin
              if (ack_q) begin
                st_q <= ST_TX;  cnt_q <= '0;
                if (!bsel_q) begin
                  tx_q <= word_q[BYTE_W-1:0];  oe_q <= ~word_q[BYTE_W-1];  bsel_q <= 1'b1;
                end else begin
                  word_q <= rd_word;  tx_q <= rd_word[WORD_W-1 -: BYTE_W];
                  oe_q <= ~rd_word[WORD_W-1];  bsel_q <= 1'b0;
                end
              end else begin
                st_q <= ST_WAIT;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  AST_IDLE_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == ST_IDLE |-> !sda_oe_o); // R11
  AST_WAIT_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == ST_WAIT |-> !sda_oe_o); // R8
  AST_TIMEOUT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmo |=> st_q == ST_IDLE && !sda_oe_o); // R10
  AST_ACK_ON_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == ST_ADDR_ACK |-> rx_q[7:1] == DEV_ADDR); // R1
  AST_PTR_FIXED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q inside {ST_TX, ST_TX_ACK}) && !autoinc_q |=> $stable(ptr_q)); // R4
endmodule

// File: tb/i2c_reg_reader_tb.sv
module i2c_reg_reader_tb;
  localparam logic [6:0] DEV = 7'h48;
  localparam int N_EXT = 3;
  localparam int TO_CYC = 2000;
  localparam int Q = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, m_low = 1'b0, sda_oe;
  logic [15:0] regs_m [N_EXT];
  logic [N_EXT*16-1:0] reg_data;
  logic [15:0] alert_set = '0, alert_m = '0;
  logic sda_bus, watch = 1'b0, oe_seen = 1'b0, done = 1'b0;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;
  assign sda_bus = ~(m_low | sda_oe);
  for (genvar g = 0; g < N_EXT; g++) begin : g_rd
    assign reg_data[g*16 +: 16] = regs_m[g];
  end

  i2c_reg_reader #(.DEV_ADDR(DEV), .N_EXT(N_EXT), .TO_CYC(TO_CYC)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_bus), .sda_oe_o(sda_oe),
    .reg_data_i(reg_data), .alert_set_i(alert_set));

  always @(negedge clk) if (watch && sda_oe) oe_seen <= 1'b1;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wq(input int n = Q);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;  m_low = 0; scl = 1; wq; m_low = 1; wq; scl = 0; wq; endtask
  task automatic bus_rstart; m_low = 0; wq; scl = 1; wq; m_low = 1; wq; scl = 0; wq; endtask
  task automatic bus_stop;   m_low = 1; wq; scl = 1; wq; m_low = 0; wq; endtask
  task automatic wbit(input logic b); m_low = ~b; wq; scl = 1; wq(2*Q); scl = 0; wq; endtask
  task automatic rbit(output logic b); m_low = 0; wq; scl = 1; wq; b = sda_bus; wq; scl = 0; wq; endtask

  task automatic wbyte(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) wbit(d[i]);
    rbit(b); ack = ~b;
  endtask

  task automatic rbyte(output logic [7:0] d, input logic ack);
    for (int i = 7; i >= 0; i--) rbit(d[i]);
    wbit(~ack);
  endtask

  function automatic logic [15:0] exp_word(input logic [3:0] p);
    if (p < N_EXT) return regs_m[p];
    if (p == N_EXT) return alert_m;
    return 16'h0000;
  endfunction

  task automatic pulse_alert(input logic [15:0] v);
    alert_set = v; @(negedge clk); alert_set = '0;
    alert_m |= v;
  endtask

  // opens a read: address(W), command, repeated START, address(R)
  task automatic open_read(input logic rs, input logic ai, input logic [3:0] p);
    logic ack;
    if (rs) bus_rstart; else bus_start;
    wbyte({DEV, 1'b0}, ack);            chk("R1 write address ack", ack, 1);
    wbyte({ai, 3'b000, p}, ack);        chk("R2 command ack", ack, 1);
    bus_rstart;
    wbyte({DEV, 1'b1}, ack);            chk("R1 read address ack", ack, 1);
  endtask

  task automatic do_read(input string tag, input logic rs, input logic ai,
                         input logic [3:0] p, input int nw);
    logic [7:0] hi, lo;
    logic [3:0] cur = p;
    logic [15:0] e = '0;
    logic inc = 0;
    open_read(rs, ai, p);
    for (int w = 0; w < nw; w++) begin
      e = exp_word(cur);
      rbyte(hi, 1);
      rbyte(lo, w != nw - 1);
      chk(tag, {hi, lo}, e);
      if (w != nw - 1 && ai) begin cur++; inc = 1; end
    end
    bus_stop;
    if (!inc && cur == N_EXT) alert_m &= ~e;
  endtask

  initial begin
    logic [7:0] d;
    logic ack, b;
    for (int i = 0; i < N_EXT; i++) regs_m[i] = 16'h1111 * (i + 3);
    void'($urandom(32'd1234));
    wq(4);
    chk("R11 SDA released in reset", {sda_oe, sda_bus}, 2'b01);
    rst_n = 1; wq(4);
    chk("R11 SDA released after reset", sda_oe, 0);

    regs_m[0] = 16'hA35C; regs_m[1] = 16'h5A0F; regs_m[2] = 16'h8001;
    do_read("R3 single word MSB first", 0, 0, 4'd0, 1);
    do_read("R4 repeated same register", 0, 0, 4'd1, 3);
    pulse_alert(16'h00A5);
    do_read("R5 R6 burst over mapped and unmapped", 0, 1, 4'd0, 5);
    do_read("R7 alert kept after burst", 0, 0, 4'd3, 1);
    do_read("R7 alert cleared by single read", 0, 0, 4'd3, 1);
    do_read("R5 pointer wraps", 0, 1, 4'd15, 2);
    do_read("R6 unmapped reads zero", 0, 0, 4'd9, 1);

    // address mismatch: no ACK, no drive until next START
    bus_start; watch = 1; oe_seen = 0;
    wbyte({DEV ^ 7'h01, 1'b1}, ack); chk("R1 wrong address not acked", ack, 0);
    rbyte(d, 1);                     chk("R1 released after mismatch", d, 8'hFF);
    chk("R1 never drove after mismatch", oe_seen, 0);
    watch = 0; bus_stop;

    // NACK after high byte: release, and no alert clear
    pulse_alert(16'h0012);
    open_read(0, 0, 4'd3);
    rbyte(d, 0); chk("R3 alert high byte", d, 8'h00);
    rbyte(d, 1); chk("R8 released after NACK", d, 8'hFF);
    bus_stop;
    do_read("R7 no clear after partial word", 0, 0, 4'd3, 1);

    // START and STOP abort a transfer in progress
    regs_m[1] = 16'hFFC3;
    open_read(0, 0, 4'd1);
    for (int i = 0; i < 3; i++) rbit(b);
    do_read("R9 repeated START aborts", 1, 0, 4'd0, 1);
    open_read(0, 0, 4'd1);
    for (int i = 0; i < 3; i++) rbit(b);
    bus_stop; wq;
    chk("R9 STOP releases SDA", sda_oe, 0);
    do_read("R9 read after STOP abort", 0, 0, 4'd2, 1);

    // timeout while target drives low
    regs_m[2] = 16'h0000;
    open_read(0, 0, 4'd2);
    chk("R3 drives first data bit low", sda_oe, 1);
    wq(TO_CYC / 2); chk("R10 held before timeout", sda_oe, 1);
    wq(TO_CYC / 2 + 50); chk("R10 released after timeout", sda_oe, 0);
    m_low = 1; wq; scl = 1; wq; m_low = 0; wq;
    regs_m[2] = 16'h3C3C;
    do_read("R10 recovers after timeout", 0, 0, 4'd2, 1);

    for (int t = 0; t < 30; t++) begin
      for (int i = 0; i < N_EXT; i++) regs_m[i] = 16'($urandom);
      if ($urandom_range(0, 1) == 1) pulse_alert(16'($urandom));
      do_read("R4 R5 R6 R7 random read", 0, 1'($urandom), 4'($urandom_range(0, 5)),
              $urandom_range(1, 4));
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule